// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register Block

This block holds the programmable state of an I/O interrupt routing controller. The bus sees only two 32-bit locations. A write to the select location chooses one internal register. The data window then reads or writes the register that the select value names. The internal registers are a 4-bit controller identifier, a read-only word that gives the version and the pin capacity, an arbitration word that always reads zero, and one 64-bit routing entry per interrupt pin. Each routing entry is reached as two 32-bit halves, at neighbouring even and odd select values.

Every routing entry is presented in full on a flat output bus, so the interrupt dispatcher can read all of them at the same time. Each time software changes either half of any entry, the block raises a one-cycle rescan request, so the dispatcher walks the pending pins again with the new settings. Read data is registered: it is valid in the cycle after the read strobe and it holds until the next read.

Top module: `irq_route_regs`

## Requirements
- R1: A write at bus offset 0x00 loads the low 8 bits of the write data into the select register. A read at offset 0x00 returns the select value zero-extended to 32 bits.
- R2: Select value 0x00 is the identifier register. A window write keeps only write-data bits 27:24. A window read returns the identifier in bits 27:24, with every other bit zero.
- R3: Select value 0x01 reads 0x11 in bits 7:0 and NUM_PINS-1 in bits 16 and up. Writes to it change nothing.
- R4: Select value 0x02 always reads 0, and writes to it change nothing.
- R5: Routing entry n sits at select 0x10+2n for bits 31:0 and at select 0x11+2n for bits 63:32. Writing one half leaves the other half unchanged. Entry n appears on `route_tbl[64n+63:64n]`.
- R6: A window read at a select value that names no register and no entry returns 0, and a window write there changes nothing. Bus offsets other than 0x00 and 0x10 read 0 and ignore writes.
- R7: Reset clears the select register, the identifier, `bus_rdata` and `rescan_req`. It sets every routing entry to 0x0000_0000_0001_0000, which is the mask bit (bit 16) alone.
- R8: `rescan_req` is high for exactly the cycle that follows each window write to a routing-entry half. It stays low after any other write.
- R9: `bus_rdata` takes the addressed value at the clock edge where `bus_rd` is high. It holds that value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Low byte of the bus address; nothing above it is decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| route_tbl | output | 64*NUM_PINS | All routing entries, entry n at bits 64n+63:64n |
| rescan_req | output | 1 | One-cycle pulse after each routing-entry half write |

## Verification
Some properties are checked by assertions on every cycle. A write to one half of an entry leaves the other half of that entry stable. The table does not change in a cycle without a write. A rescan pulse always follows a write to an entry half. The identifier, version and arbitration reads return their fixed shapes, and read data holds between reads. Other behaviour can only be shown by the bench's scenarios against its own register model. These are the reset contents, the even/odd mapping at the first and last pins, and the select values just past the table. They also include the bus offsets that decode to nothing, and a long random mix of select, read and write accesses.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [7:0] OFF_SELECT   = 8'h00;
    localparam logic [7:0] OFF_WINDOW   = 8'h10;

    localparam logic [7:0] IDX_IDENT    = 8'h00;
    localparam logic [7:0] IDX_VERSION  = 8'h01;
    localparam logic [7:0] IDX_ARBIT    = 8'h02;
    localparam logic [7:0] IDX_TBL_BASE = 8'h10;

    localparam logic [7:0] VERSION_CODE = 8'h11;
    localparam int         IDENT_LSB    = 24;
    localparam int         IDENT_W      = 4;
    localparam int         CAP_LSB      = 16;
    localparam int         MASK_BIT     = 16;
    localparam int         PIN_IDX_W    = 7;
    localparam int         ENTRY_W      = 64;
    localparam int         HALF_W       = 32;

    typedef enum logic [2:0] {
        TGT_IDENT,
        TGT_VERSION,
        TGT_ARBIT,
        TGT_ENT_LO,
        TGT_ENT_HI,
        TGT_NONE
    } sel_target_e;

    typedef struct packed {
        sel_target_e            kind;
        logic [PIN_IDX_W-1:0]   pin;
    } sel_decode_t;

    function automatic logic [ENTRY_W-1:0] entry_reset_value();
        logic [ENTRY_W-1:0] v;
        v = '0;
        v[MASK_BIT] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] version_word(input int npins);
        logic [31:0] w;
        w = {24'h0, VERSION_CODE};
        w[CAP_LSB +: 8] = 8'(npins - 1);
        return w;
    endfunction

    function automatic sel_decode_t decode_select(input logic [7:0] sel, input int npins);
        sel_decode_t d;
        logic [8:0]  limit;
        logic [7:0]  rel;
        limit = 9'(32'(IDX_TBL_BASE) + 2 * npins);
        rel   = sel - IDX_TBL_BASE;
        d.pin = '0;
        if (sel == IDX_IDENT)             d.kind = TGT_IDENT;
        else if (sel == IDX_VERSION)      d.kind = TGT_VERSION;
        else if (sel == IDX_ARBIT)        d.kind = TGT_ARBIT;
        else if (sel >= IDX_TBL_BASE && {1'b0, sel} < limit) begin
            d.kind = rel[0] ? TGT_ENT_HI : TGT_ENT_LO;
            d.pin  = rel[PIN_IDX_W:1];
        end
        else                              d.kind = TGT_NONE;
        return d;
    endfunction

endpackage

// File: rtl/irq_route_sel_decode.sv
module irq_route_sel_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [7:0]  sel,
    output sel_decode_t dec
);
    always_comb begin
        dec = decode_select(sel, NUM_PINS);
    end
endmodule

// File: rtl/irq_route_entry_bank.sv
module irq_route_entry_bank
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int TBL_W   = NUM_PINS * ENTRY_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic [PIN_IDX_W-1:0] wr_pin,
    input  logic [HALF_W-1:0]    wr_data,
    output logic [TBL_W-1:0]     tbl,
    output logic                 rescan
);
    localparam logic [ENTRY_W-1:0] RST_ENTRY = entry_reset_value();

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [HALF_W-1:0] lo_q;
        logic [HALF_W-1:0] hi_q;
        logic              hit;

        assign hit = wr_en && (wr_pin == PIN_IDX_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q <= RST_ENTRY[HALF_W-1:0];
                hi_q <= RST_ENTRY[ENTRY_W-1:HALF_W];
            end else if (hit) begin
                if (wr_hi) hi_q <= wr_data;
                else       lo_q <= wr_data;
            end
        end

        assign tbl[p*ENTRY_W +: ENTRY_W] = {hi_q, lo_q};
    end

    always_ff @(posedge clk) begin
        if (rst) rescan <= 1'b0;
        else     rescan <= wr_en;
    end
endmodule

// File: rtl/irq_route_read_port.sv
module irq_route_read_port
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int TBL_W   = NUM_PINS * ENTRY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd,
    input  logic [7:0]         off,
    input  logic [7:0]         sel,
    input  logic [IDENT_W-1:0] ident,
    input  sel_decode_t        dec,
    input  logic [TBL_W-1:0]   tbl,
    output logic [31:0]        rdata
);
    localparam logic [31:0] VER_WORD = version_word(NUM_PINS);

    logic [ENTRY_W-1:0] ent;
    logic [31:0]        win_val;
    logic [31:0]        nxt;

    always_comb begin
        ent = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (dec.pin == PIN_IDX_W'(p)) ent = tbl[p*ENTRY_W +: ENTRY_W];
        end
    end

    always_comb begin
        win_val = '0;
        unique case (dec.kind)
            TGT_IDENT:   win_val[IDENT_LSB +: IDENT_W] = ident;
            TGT_VERSION: win_val = VER_WORD;
            TGT_ENT_LO:  win_val = ent[HALF_W-1:0];
            TGT_ENT_HI:  win_val = ent[ENTRY_W-1:HALF_W];
            default:     win_val = '0;
        endcase
    end

    always_comb begin
        if (off == OFF_SELECT)      nxt = {24'h0, sel};
        else if (off == OFF_WINDOW) nxt = win_val;
        else                        nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= nxt;
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int TBL_W   = NUM_PINS * ENTRY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic [TBL_W-1:0] route_tbl,
    output logic             rescan_req
);
    logic [7:0]         sel_q;
    logic [IDENT_W-1:0] ident_q;
    sel_decode_t        dec;
    logic               sel_wr;
    logic               win_wr;
    logic               ent_wr;

    assign sel_wr = bus_wr && (bus_addr == OFF_SELECT);
    assign win_wr = bus_wr && (bus_addr == OFF_WINDOW);
    assign ent_wr = win_wr && (dec.kind == TGT_ENT_LO || dec.kind == TGT_ENT_HI);

    irq_route_sel_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .sel (sel_q),
        .dec (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            ident_q <= '0;
        end else begin
            if (sel_wr) sel_q <= bus_wdata[7:0];
            if (win_wr && dec.kind == TGT_IDENT)
                ident_q <= bus_wdata[IDENT_LSB +: IDENT_W];
        end
    end

    irq_route_entry_bank #(.NUM_PINS(NUM_PINS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ent_wr),
        .wr_hi   (dec.kind == TGT_ENT_HI),
        .wr_pin  (dec.pin),
        .wr_data (bus_wdata),
        .tbl     (route_tbl),
        .rescan  (rescan_req)
    );

    irq_route_read_port #(.NUM_PINS(NUM_PINS)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .off   (bus_addr),
        .sel   (sel_q),
        .ident (ident_q),
        .dec   (dec),
        .tbl   (route_tbl),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
    parameter int NUM_PINS = 24,
    localparam int TBL_W   = NUM_PINS * 64
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [TBL_W-1:0] route_tbl,
    input logic             rescan_req,
    input logic [7:0]       sel_q
);
    logic       win_rd;
    logic       win_wr;
    logic       sel_in_tbl;
    logic [31:0] ver_exp;

    assign win_rd     = bus_rd && bus_addr == 8'h10;
    assign win_wr     = bus_wr && bus_addr == 8'h10;
    assign sel_in_tbl = sel_q >= 8'h10 && {1'b0, sel_q} < 9'(16 + 2 * NUM_PINS);
    assign ver_exp    = 32'h11 | (32'(NUM_PINS - 1) << 16);

    a_r2_ident_shape: assert property (@(posedge clk) disable iff (rst)
        win_rd && sel_q == 8'h00 |=> bus_rdata[23:0] == 24'h0 && bus_rdata[31:28] == 4'h0);

    a_r3_version_word: assert property (@(posedge clk) disable iff (rst)
        win_rd && sel_q == 8'h01 |=> bus_rdata == ver_exp);

    a_r4_arbit_zero: assert property (@(posedge clk) disable iff (rst)
        win_rd && sel_q == 8'h02 |=> bus_rdata == 32'h0);

    a_r6_tbl_quiet: assert property (@(posedge clk) disable iff (rst)
        !(win_wr && sel_in_tbl) |=> $stable(route_tbl));

    a_r8_rescan_cause: assert property (@(posedge clk) disable iff (rst)
        !(win_wr && sel_in_tbl) |=> !rescan_req);

    a_r8_rescan_after_write: assert property (@(posedge clk) disable iff (rst)
        win_wr && sel_in_tbl |=> rescan_req);

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_half
        a_r5_hi_kept: assert property (@(posedge clk) disable iff (rst)
            win_wr && sel_q == 8'(16 + 2 * p) |=> $stable(route_tbl[p*64+32 +: 32]));
        a_r5_lo_kept: assert property (@(posedge clk) disable iff (rst)
            win_wr && sel_q == 8'(17 + 2 * p) |=> $stable(route_tbl[p*64 +: 32]));
    end
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .route_tbl  (route_tbl),
    .rescan_req (rescan_req),
    .sel_q      (sel_q)
);

// File: tb/irq_route_regs_bench.sv
`timescale 1ns/1ps
module irq_route_regs_bench;
    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N*64-1:0] route_tbl;
    logic          rescan_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [63:0] m_tbl [N];

    always #4 clk = ~clk;

    irq_route_regs #(.NUM_PINS(N)) u_irq_route_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .route_tbl(route_tbl), .rescan_req(rescan_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit sel_is_entry(input logic [7:0] s);
        return s >= 8'h10 && int'(s) < 16 + 2 * N;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int pin;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h00) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return 32'h11 | (32'(N - 1) << 16);
        if (m_sel == 8'h02) return 32'h0;
        if (sel_is_entry(m_sel)) begin
            pin = (int'(m_sel) - 16) / 2;
            return m_sel[0] ? m_tbl[pin][63:32] : m_tbl[pin][31:0];
        end
        return 32'h0;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input string req);
        bit expect_rescan;
        int pin;
        expect_rescan = (a == 8'h10) && sel_is_entry(m_sel);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h00) m_sel = d[7:0];
        else if (a == 8'h10) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (sel_is_entry(m_sel)) begin
                pin = (int'(m_sel) - 16) / 2;
                if (m_sel[0]) m_tbl[pin][63:32] = d;
                else          m_tbl[pin][31:0]  = d;
            end
        end
        check({"R8 rescan ", req}, 64'(rescan_req), 64'(expect_rescan));
    endtask

    task automatic bus_read(input logic [7:0] a, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check({"R9 read ", req}, 64'(bus_rdata), 64'(exp_read(a)));
    endtask

    task automatic check_table(input string req);
        for (int p = 0; p < N; p++)
            check(req, route_tbl[p*64 +: 64], m_tbl[p]);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        m_sel = '0; m_id = '0;
        for (int p = 0; p < N; p++) m_tbl[p] = 64'h0000_0000_0001_0000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check("R7 rdata after reset", 64'(bus_rdata), 64'h0);
        check("R7 rescan after reset", 64'(rescan_req), 64'h0);
        check_table("R7 entry reset value");
        bus_read(8'h00, "R7 select cleared");
        bus_read(8'h10, "R7 ident cleared");

        // R1 select register and readback
        bus_write(8'h00, 32'hDEAD_BE3C, "R1 select write");
        bus_read(8'h00, "R1 select readback");

        // R2 identifier keeps bits 27:24 only
        bus_write(8'h00, 32'h0, "R2 select ident");
        bus_write(8'h10, 32'hFFFF_FFFF, "R2 ident write");
        bus_read(8'h10, "R2 ident readback");
        check("R2 ident value", 64'(bus_rdata), 64'h0F00_0000);

        // R3 version read-only
        bus_write(8'h00, 32'h1, "R3 select version");
        bus_write(8'h10, 32'h1234_5678, "R3 version write ignored");
        bus_read(8'h10, "R3 version word");
        check("R3 version value", 64'(bus_rdata), 64'h0017_0011);

        // R4 arbitration
        bus_write(8'h00, 32'h2, "R4 select arbit");
        bus_write(8'h10, 32'hFFFF_FFFF, "R4 arbit write ignored");
        bus_read(8'h10, "R4 arbit zero");

        // R5 halves of first and last entry
        bus_write(8'h00, 32'h10, "R5 select pin0 lo");
        bus_write(8'h10, 32'hA5A5_0042, "R5 pin0 lo write");
        check_table("R5 lo write keeps hi");
        bus_write(8'h00, 32'h11, "R5 select pin0 hi");
        bus_write(8'h10, 32'h0F00_0000, "R5 pin0 hi write");
        check_table("R5 hi write keeps lo");
        bus_read(8'h10, "R5 pin0 hi readback");
        bus_write(8'h00, 32'(15 + 2 * N), "R5 select last hi");
        bus_write(8'h10, 32'hC0DE_0001, "R5 last hi write");
        check_table("R5 last entry");
        bus_read(8'h10, "R5 last hi readback");

        // R6 unmapped select and offsets
        bus_write(8'h00, 32'(16 + 2 * N), "R6 select past table");
        bus_write(8'h10, 32'hFFFF_FFFF, "R6 unmapped write");
        check_table("R6 unmapped write no effect");
        bus_read(8'h10, "R6 unmapped read zero");
        bus_write(8'h00, 32'h3, "R6 select index 3");
        bus_read(8'h10, "R6 index 3 zero");
        bus_write(8'h08, 32'h10, "R6 stray offset write");
        bus_read(8'h00, "R6 select untouched");
        bus_read(8'h04, "R6 stray offset read");

        // R9 hold between reads
        bus_write(8'h00, 32'h0, "R9 select ident");
        bus_read(8'h10, "R9 read before hold");
        held = bus_rdata;
        bus_write(8'h10, 32'h0300_0000, "R9 ident change");
        repeat (4) @(negedge clk);
        check("R9 rdata held", 64'(bus_rdata), 64'(held));

        // random mix
        for (int i = 0; i < 600; i++) begin
            int kind;
            logic [7:0] a;
            kind = int'($urandom_range(0, 9));
            if (kind < 3) begin
                a = ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'($urandom_range(0, 16 + 2 * N + 2));
                bus_write(8'h00, {24'($urandom), a}, "R1 random select");
            end else if (kind < 6) begin
                bus_write(8'h10, $urandom, "R5 random window write");
                check_table("R5 random table");
            end else if (kind == 6) begin
                bus_write(8'($urandom_range(1, 255)) & 8'hEF, $urandom, "R6 random stray write");
            end else begin
                a = ($urandom_range(0, 1) == 0) ? 8'h10 : 8'h00;
                bus_read(a, "R5 random read");
            end
        end

        finished = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end
endmodule